// File: doc/BRIEF.md
# 32-bit Integer ALU with Signed Overflow Detection

This block is the combinational execution unit of a small 32-bit RISC integer pipeline. It takes two 32-bit operands, a 16-bit immediate, a 5-bit shift amount and a 6-bit function code. It returns a 32-bit result, a flag that is high when the result is zero, and a flag for signed overflow. The function code uses the fixed register-format values: add, subtract, and, or, nor, logical shift left, logical shift right and set-on-less-than.

A 2-bit source-mode input chooses the second operand. It can be the register operand, the sign-extended immediate (used for add-immediate and set-less-than-immediate), or the zero-extended immediate (used for and-immediate and or-immediate). A fourth mode is the upper-immediate load. In that mode the immediate goes into the top half of the result and the function code is ignored. A separate signedness input makes add and subtract unsigned, which removes their overflow, and makes set-on-less-than compare as unsigned.

The decoder drives all inputs in the same cycle and reads all outputs in that cycle. The block holds no state and has no clock. Whatever sits downstream decides whether an overflow traps.

Top module: `int_alu32`

## Requirements
- R1: Function code 32 gives a + b, 34 gives a − b, 36 gives a AND b, and 37 gives a OR b. In each case b is the second operand selected by the source mode, and all results are modulo 2^32.
- R2: Function code 42 gives 1 when a < b and 0 otherwise. The comparison is two's complement when `sign_off_i` = 0 and unsigned when `sign_off_i` = 1.
- R3: Function code 0 shifts operand a left by `shamt_i` and function code 2 shifts it right by `shamt_i`. Both shifts fill with zeros, and every amount from 0 to 31 is honoured.
- R4: With `sign_off_i` = 0, function codes 32 and 34 raise `ovf_o` exactly when the true signed sum or difference lies outside −2^31 … 2^31−1.
- R5: `ovf_o` is 0 whenever `sign_off_i` = 1, for every function code other than 32 and 34, and in upper-immediate mode.
- R6: Function code 39 gives the bitwise inverse of (a OR b).
- R7: Source mode 0 uses `b_i` as the second operand. Mode 1 uses `imm_i` sign-extended from bit 15. Mode 2 uses `imm_i` with bits 31:16 set to zero.
- R8: Source mode 3 gives `imm_i` in bits 31:16 and zeros in bits 15:0, whatever the function code.
- R9: `zero_o` is 1 exactly when all 32 bits of `result_o` are 0.
- R10: Any function code other than 0, 2, 32, 34, 36, 37, 39 and 42, outside mode 3, gives a result of 0 and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Register second operand |
| imm_i | input | 16 | Instruction immediate |
| shamt_i | input | 5 | Shift amount |
| func_i | input | 6 | Function code |
| src_mode_i | input | 2 | 0 register, 1 sign-extended imm, 2 zero-extended imm, 3 upper-immediate load |
| sign_off_i | input | 1 | 1 selects unsigned arithmetic and comparison |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow on add or subtract |

## Verification
The hardest outputs to reach are the exact overflow boundaries and the cases where the signed and unsigned less-than answers disagree. Uniformly random operands almost never reach them. The stimulus therefore draws operands from a biased pool containing 0, 1, all-ones, 0x7FFFFFFF and 0x80000000 and their neighbours, and crosses each pool value with both signedness settings. Directed vectors cover the cases where the result wraps to exactly zero, where the sign-extended immediate is negative, and shift amounts of 0 and 31.

// File: rtl/alu32_pkg.sv
// alu32_pkg: function codes and operand-source modes shared by the ALU
// modules and any decoder that drives them. The function codes are fixed
// by the instruction encoding and must not be renumbered.
package alu32_pkg;

    typedef enum logic [5:0] {
        FN_SLL = 6'd0,
        FN_SRL = 6'd2,
        FN_ADD = 6'd32,
        FN_SUB = 6'd34,
        FN_AND = 6'd36,
        FN_OR  = 6'd37,
        FN_NOR = 6'd39,
        FN_SLT = 6'd42
    } alu_fn_e;

    typedef enum logic [1:0] {
        SRC_REG    = 2'd0,
        SRC_IMM_SX = 2'd1,
        SRC_IMM_ZX = 2'd2,
        SRC_UPPER  = 2'd3
    } src_mode_e;

endpackage

// File: rtl/alu_opnd_sel.sv
// alu_opnd_sel: picks the second ALU operand from the register value or
// the immediate, which it widens by sign or by zero extension.
// Assumes IMM_W < DATA_W. Mode SRC_UPPER returns the register value,
// because the top level overrides the result in that mode.
module alu_opnd_sel
    import alu32_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [1:0]        mode_i,
    output logic [DATA_W-1:0] opnd_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] imm_zx;

    // Widen the immediate both ways.
    always_comb begin
        imm_sx = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        imm_zx = {{EXT_W{1'b0}}, imm_i};
    end

    // Choose the operand by mode.
    always_comb begin
        case (mode_i)
            SRC_IMM_SX: opnd_o = imm_sx;
            SRC_IMM_ZX: opnd_o = imm_zx;
            default:    opnd_o = reg_b_i;
        endcase
    end

    // An immediate mode never shows bits of the register operand above the immediate.
    always_comb begin
        if (!$isunknown({mode_i, imm_i})) begin
            if (mode_i == SRC_IMM_ZX)
                AST_ZX_UPPER_CLEAR: assert (opnd_o[DATA_W-1:IMM_W] == '0) else $error("zx upper bits set"); // R7
            if (mode_i == SRC_IMM_SX)
                AST_SX_UPPER_COPY: assert (opnd_o[DATA_W-1] == imm_i[IMM_W-1]) else $error("sx sign lost"); // R7
        end
    end

endmodule

// File: rtl/alu_arith.sv
// alu_arith: one shared adder that does add, subtract and the
// less-than compare. A subtract inverts b and feeds a carry-in of one.
// The less-than result comes from the difference: signed uses
// sign XOR overflow, unsigned uses the inverted carry-out.
// Assumes the caller requests subtraction whenever it wants a compare.
module alu_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              uns_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o,
    output logic              lt_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_x;
    logic              carry;
    logic              ovf_raw;

    // Condition operand b and run the single adder.
    always_comb begin
        b_x            = sub_i ? ~b_i : b_i;
        {carry, sum_o} = {1'b0, a_i} + {1'b0, b_x} + {{DATA_W{1'b0}}, sub_i};
    end

    // Derive signed overflow and the two less-than flavours.
    always_comb begin
        ovf_raw = (a_i[MSB] == b_x[MSB]) && (sum_o[MSB] != a_i[MSB]);
        ovf_o   = ovf_raw && !uns_i;
        lt_o    = uns_i ? !carry : (sum_o[MSB] ^ ovf_raw);
    end

    // On overflow the sign of the wrapped result differs from that of a.
    always_comb begin
        if (!$isunknown({a_i, b_i, sub_i, uns_i})) begin
            if (ovf_o)
                AST_OVF_SIGN_FLIP: assert (sum_o[MSB] != a_i[MSB]) else $error("ovf without sign flip"); // R4
            if (sub_i && a_i == b_i)
                AST_EQ_NOT_LESS: assert (!lt_o && sum_o == '0) else $error("equal operands compare less"); // R2
        end
    end

endmodule

// File: rtl/alu_logic_shift.sv
// alu_logic_shift: the bitwise and logical-shift side of the ALU.
// It returns the result of whichever of and, or, nor, sll or srl the
// function code names, and zero for any other code. Shifts act on a.
module alu_logic_shift
    import alu32_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5,
    parameter int FUNC_W  = 6
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [FUNC_W-1:0]  func_i,
    output logic [DATA_W-1:0]  res_o
);
    logic [DATA_W-1:0] or_v;

    // Shared OR term feeds both or and nor.
    always_comb or_v = a_i | b_i;

    // Select the bitwise or shift result.
    always_comb begin
        case (func_i)
            FN_AND:  res_o = a_i & b_i;
            FN_OR:   res_o = or_v;
            FN_NOR:  res_o = ~or_v;
            FN_SLL:  res_o = a_i << shamt_i;
            FN_SRL:  res_o = a_i >> shamt_i;
            default: res_o = '0;
        endcase
    end

    // A shift by zero leaves the operand untouched, and nor never shares a set bit with a.
    always_comb begin
        if (!$isunknown({a_i, b_i, shamt_i, func_i})) begin
            if ((func_i == FN_SLL || func_i == FN_SRL) && shamt_i == '0)
                AST_SHIFT_ZERO_IDENT: assert (res_o == a_i) else $error("shift by 0 changed operand"); // R3
            if (func_i == FN_NOR)
                AST_NOR_DISJOINT: assert ((res_o & a_i) == '0) else $error("nor overlaps a"); // R6
        end
    end

endmodule

// File: rtl/int_alu32.sv
// int_alu32: the top level of the combinational integer ALU. It wires the
// operand selector, the shared adder and the logic/shift unit together,
// then merges their outputs by function code. Upper-immediate mode takes
// priority over the function code. Overflow can only come from add and
// subtract. Assumes all inputs are stable within the cycle that uses them.
module int_alu32
    import alu32_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHAMT_W = 5,
    parameter int FUNC_W  = 6
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [FUNC_W-1:0]  func_i,
    input  logic [1:0]         src_mode_i,
    input  logic               sign_off_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               zero_o,
    output logic               ovf_o
);
    localparam int LOW_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] ls_res;
    logic              arith_ovf;
    logic              arith_lt;
    logic              use_sub;
    logic              is_addsub;
    logic              is_upper;

    // Decode the few controls the adder and the merge need.
    always_comb begin
        use_sub   = (func_i == FN_SUB) || (func_i == FN_SLT);
        is_addsub = (func_i == FN_ADD) || (func_i == FN_SUB);
        is_upper  = (src_mode_i == SRC_UPPER);
    end

    alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .reg_b_i (b_i),
        .imm_i   (imm_i),
        .mode_i  (src_mode_i),
        .opnd_o  (opnd_b)
    );

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a_i   (a_i),
        .b_i   (opnd_b),
        .sub_i (use_sub),
        .uns_i (sign_off_i),
        .sum_o (sum),
        .ovf_o (arith_ovf),
        .lt_o  (arith_lt)
    );

    alu_logic_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .FUNC_W(FUNC_W)) u_ls (
        .a_i     (a_i),
        .b_i     (opnd_b),
        .shamt_i (shamt_i),
        .func_i  (func_i),
        .res_o   (ls_res)
    );

    // Merge the unit outputs into the final result.
    always_comb begin
        if (is_upper)
            result_o = {imm_i, {LOW_W{1'b0}}};
        else if (is_addsub)
            result_o = sum;
        else if (func_i == FN_SLT)
            result_o = {{(DATA_W-1){1'b0}}, arith_lt};
        else
            result_o = ls_res;
    end

    // Flags: zero detect and gated overflow.
    always_comb begin
        zero_o = (result_o == '0);
        ovf_o  = arith_ovf && is_addsub && !is_upper;
    end

    // Port-level checks on overflow gating, compare width, the upper load and unknown codes.
    always_comb begin
        if (!$isunknown({a_i, b_i, imm_i, shamt_i, func_i, src_mode_i, sign_off_i})) begin
            if (sign_off_i || is_upper)
                AST_NO_OVERFLOW: assert (!ovf_o) else $error("overflow in unsigned/upper mode"); // R5
            if (!is_upper && func_i == FN_SLT)
                AST_SLT_BOOLEAN: assert (result_o[DATA_W-1:1] == '0) else $error("slt wider than 1 bit"); // R2
            if (is_upper)
                AST_UPPER_LOW_CLEAR: assert (result_o[LOW_W-1:0] == '0 && result_o[DATA_W-1:LOW_W] == imm_i) else $error("upper load wrong"); // R8
            if (!is_upper && !is_addsub && func_i != FN_SLT && func_i != FN_AND && func_i != FN_OR
                && func_i != FN_NOR && func_i != FN_SLL && func_i != FN_SRL)
                AST_UNKNOWN_FUNC_ZERO: assert (result_o == '0 && !ovf_o && zero_o) else $error("unknown func not zero"); // R10
        end
    end

endmodule

// File: tb/sim_int_alu32.sv
// sim_int_alu32: drives vectors on the falling edge and compares every
// output against a behavioural model one nanosecond after the rising edge.
module sim_int_alu32;

    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [15:0] imm;
    logic [4:0]  sh;
    logic [5:0]  fn;
    logic [1:0]  mode;
    logic        uns;
    logic [31:0] res;
    logic        zf, of;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    int_alu32 u0 (
        .a_i(a), .b_i(b), .imm_i(imm), .shamt_i(sh), .func_i(fn),
        .src_mode_i(mode), .sign_off_i(uns),
        .result_o(res), .zero_o(zf), .ovf_o(of)
    );

    // Behavioural model of the requirements.
    function automatic void model(input logic [31:0] ma, mb, input logic [15:0] mi,
                                  input logic [4:0] ms, input logic [5:0] mf,
                                  input logic [1:0] mm, input logic mu,
                                  output logic [31:0] er, output logic eo);
        logic [31:0] bb;
        longint      s;
        int          si;
        si = $signed(mi);
        bb = (mm == 2'd1) ? 32'(si) : (mm == 2'd2) ? {16'h0, mi} : mb;  // R7
        er = 32'h0;
        eo = 1'b0;
        if (mm == 2'd3) begin
            er = {mi, 16'h0};                                          // R8
        end else begin
            case (mf)
                6'd32, 6'd34: begin                                    // R1 R4
                    if (mf == 6'd32) s = longint'($signed(ma)) + longint'($signed(bb));
                    else             s = longint'($signed(ma)) - longint'($signed(bb));
                    er = s[31:0];
                    eo = !mu && (s > 64'sd2147483647 || s < -64'sd2147483648);
                end
                6'd36: er = ma & bb;
                6'd37: er = ma | bb;
                6'd39: er = ~(ma | bb);                                // R6
                6'd0:  er = ma << ms;                                  // R3
                6'd2:  er = ma >> ms;
                6'd42: er = mu ? {31'h0, ma < bb} : {31'h0, $signed(ma) < $signed(bb)}; // R2
                default: er = 32'h0;                                   // R10
            endcase
        end
    endfunction

    function automatic string res_tag(input logic [5:0] mf, input logic [1:0] mm);
        if (mm == 2'd3) return "R8";
        if (mm != 2'd0) return "R7";
        case (mf)
            6'd32, 6'd34, 6'd36, 6'd37: return "R1";
            6'd42: return "R2";
            6'd0, 6'd2: return "R3";
            6'd39: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input logic [31:0] ta, tb, input logic [15:0] ti,
                         input logic [4:0] ts, input logic [5:0] tf,
                         input logic [1:0] tm, input logic tu);
        logic [31:0] er;
        logic        eo;
        string       ot;
        @(negedge clk);
        a = ta; b = tb; imm = ti; sh = ts; fn = tf; mode = tm; uns = tu;
        model(ta, tb, ti, ts, tf, tm, tu, er, eo);
        @(posedge clk);
        #1;
        n_chk++;
        if (res !== er) begin
            n_fail++;
            $display("FAIL %s result fn=%0d mode=%0d: actual %h expected %h", res_tag(tf, tm), tf, tm, res, er);
        end
        ot = ((tf == 6'd32 || tf == 6'd34) && !tu && tm != 2'd3) ? "R4" : "R5";
        n_chk++;
        if (of !== eo) begin
            n_fail++;
            $display("FAIL %s overflow fn=%0d: actual %b expected %b", ot, tf, of, eo);
        end
        n_chk++;
        if (zf !== (er == 32'h0)) begin
            n_fail++;
            $display("FAIL R9 zero flag: actual %b expected %b", zf, er == 32'h0);
        end
    endtask

    function automatic logic [31:0] pick_opnd();
        case ($urandom_range(0, 9))
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h7FFF_FFFE;
            6: return 32'h8000_0001;
            default: return $urandom;
        endcase
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        a = '0; b = '0; imm = '0; sh = '0; fn = 6'd32; mode = '0; uns = 1'b0;
        // Initial state: 0 + 0 gives zero flag (R9)
        apply(32'h0, 32'h0, 16'h0, 5'd0, 6'd32, 2'd0, 1'b0);
        // R4 overflow boundaries, R5 unsigned suppression
        apply(32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 6'd32, 2'd0, 1'b0);
        apply(32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 6'd32, 2'd0, 1'b1);
        apply(32'h8000_0000, 32'h1, 16'h0, 5'd0, 6'd34, 2'd0, 1'b0);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0, 6'd32, 2'd0, 1'b0);
        apply(32'h8000_0000, 32'h8000_0000, 16'h0, 5'd0, 6'd32, 2'd0, 1'b0);
        apply(32'h0, 32'h8000_0000, 16'h0, 5'd0, 6'd34, 2'd0, 1'b0);
        // R2 signed vs unsigned compare
        apply(32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 6'd42, 2'd0, 1'b0);
        apply(32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 6'd42, 2'd0, 1'b1);
        apply(32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0, 6'd42, 2'd0, 1'b0);
        apply(32'h5, 32'h5, 16'h0, 5'd0, 6'd42, 2'd0, 1'b0);
        // R3 shift extremes
        apply(32'h8000_0001, 32'h0, 16'h0, 5'd0, 6'd0, 2'd0, 1'b0);
        apply(32'h8000_0001, 32'h0, 16'h0, 5'd31, 6'd0, 2'd0, 1'b0);
        apply(32'h8000_0001, 32'h0, 16'h0, 5'd31, 6'd2, 2'd0, 1'b0);
        // R1 R6 bitwise
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0, 6'd36, 2'd0, 1'b0);
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0, 6'd37, 2'd0, 1'b0);
        apply(32'h0000_00F0, 32'h0000_00A7, 16'h0, 5'd0, 6'd39, 2'd0, 1'b0);
        // R7 immediate extension, R8 upper load
        apply(32'h0000_0010, 32'hDEAD_BEEF, 16'hFFFF, 5'd0, 6'd32, 2'd1, 1'b0);
        apply(32'h1234_5678, 32'hDEAD_BEEF, 16'hFFFF, 5'd0, 6'd36, 2'd2, 1'b0);
        apply(32'h0000_0000, 32'hDEAD_BEEF, 16'h8000, 5'd0, 6'd42, 2'd1, 1'b0);
        apply(32'h0000_0000, 32'hDEAD_BEEF, 16'h8000, 5'd0, 6'd42, 2'd1, 1'b1);
        apply(32'h7FFF_FFFF, 32'h0, 16'h8001, 5'd7, 6'd32, 2'd3, 1'b0);
        apply(32'h7FFF_FFFF, 32'h0, 16'h0000, 5'd7, 6'd63, 2'd3, 1'b0);
        // R10 unknown codes
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd3, 6'd1, 2'd0, 1'b0);
        apply(32'h7FFF_FFFF, 32'h1, 16'h0, 5'd3, 6'd33, 2'd0, 1'b0);
        // Biased random sweep
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] rf;
            case ($urandom_range(0, 9))
                0: rf = 6'd32; 1: rf = 6'd34; 2: rf = 6'd36; 3: rf = 6'd37;
                4: rf = 6'd39; 5: rf = 6'd0;  6: rf = 6'd2;  7: rf = 6'd42;
                default: rf = 6'($urandom);
            endcase
            apply(pick_opnd(), pick_opnd(), 16'($urandom), 5'($urandom), rf,
                  2'($urandom), 1'($urandom));
        end
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

endmodule